// File: doc/BRIEF.md
# Two-Slot Register Renamer

This block translates architectural register numbers into physical register tags for a core front end that hands over up to two instructions per clock. Each slot carries two source register numbers and one optional destination. In the same cycle the block looks up all four sources, takes a fresh physical tag from a pool of unused tags for every destination, reports the tag each destination used to map to, and updates its mapping table. A later slot that depends on an earlier slot of the same group sees the earlier slot's new tag.

Released tags come back through a two-wide retire port and are queued at the back of a circular free queue. A tag is released only when the instruction that replaced its mapping retires. The pipeline that feeds the block reports that event. If the queue holds fewer tags than the group needs, the block drops `ready` and leaves all of its state unchanged for that cycle.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i, `ready` is high, and the free queue hands out tags NUM_ARCH, NUM_ARCH+1, ... in ascending order.
- R2: Each valid slot's two source outputs give the current table mapping of their architectural registers, unless R5 applies.
- R3: Every slot that is valid and has its destination enabled receives a new tag from the head of the free queue. Slot 0 takes its tag before slot 1. A slot that is invalid or has no destination consumes no tag.
- R4: Each allocating slot's previous-tag output is the mapping its destination had before this group.
- R5: When slot 0 allocates and a source of slot 1 names slot 0's destination, that source output is slot 0's new tag.
- R6: When both slots write the same architectural register, the table afterwards holds slot 1's tag, and slot 1's previous-tag output is slot 0's new tag.
- R7: When the free queue holds fewer tags than the group needs, `ready` is low. No tag is consumed and the table is unchanged. A group that needs no tag is always accepted.
- R8: The retire port accepts up to two tags per cycle, slot 0 queued first. A tag retired in a cycle can be handed out no earlier than the next cycle.
- R9: The free queue is first-in first-out across its wrap point: tags retired one after another are handed out in the order they were retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid0 | input | 1 | Slot 0 holds an instruction |
| dstEn0 | input | 1 | Slot 0 writes a destination |
| srcA0 | input | 4 | Slot 0 first source register |
| srcB0 | input | 4 | Slot 0 second source register |
| dst0 | input | 4 | Slot 0 destination register |
| valid1 | input | 1 | Slot 1 holds an instruction |
| dstEn1 | input | 1 | Slot 1 writes a destination |
| srcA1 | input | 4 | Slot 1 first source register |
| srcB1 | input | 4 | Slot 1 second source register |
| dst1 | input | 4 | Slot 1 destination register |
| ready | output | 1 | Group is accepted this cycle |
| physA0 | output | 8 | Slot 0 first source tag |
| physB0 | output | 8 | Slot 0 second source tag |
| physDst0 | output | 8 | Slot 0 new destination tag |
| physOld0 | output | 8 | Slot 0 tag previously mapped to its destination |
| physA1 | output | 8 | Slot 1 first source tag |
| physB1 | output | 8 | Slot 1 second source tag |
| physDst1 | output | 8 | Slot 1 new destination tag |
| physOld1 | output | 8 | Slot 1 tag previously mapped to its destination |
| relValid0 | input | 1 | Retire port slot 0 carries a tag |
| relTag0 | input | 8 | Retire port slot 0 tag |
| relValid1 | input | 1 | Retire port slot 1 carries a tag |
| relTag1 | input | 8 | Retire port slot 1 tag |

## Verification
The queue-bound assertions assume that the retire port only returns tags that were handed out earlier and are not yet free. That keeps the free count at or below the queue depth. The stimulus returns only previous-tag values that the block itself reported, and each one only once. The fresh-tag assertion assumes no duplicate tag sits in the queue, which follows from the same rule. Exhaustion is reached only by allocation, so `ready` and the no-underflow property are exercised with the queue empty and with one tag left.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic req0;    // slot 0 wants a destination tag
    logic alloc0;  // slot 0 takes a tag this cycle
    logic alloc1;  // slot 1 takes a tag this cycle
    logic push0;   // retire slot 0 returns a tag
    logic push1;   // retire slot 1 returns a tag
  } rnStrobe_t;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 192,
  localparam int TW = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    popCnt,
  input  logic          push0,
  input  logic [TW-1:0] pushTag0,
  input  logic          push1,
  input  logic [TW-1:0] pushTag1,
  output logic [TW-1:0] headTag0,
  output logic [TW-1:0] headTag1,
  output logic [CW-1:0] freeCount
);
  logic [TW-1:0] slotMem [DEPTH];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] countQ;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p, input logic [1:0] n);
    logic [PW:0] sum;
    sum = {1'b0, p} + (PW+1)'(n);
    if (sum >= (PW+1)'(DEPTH)) sum = sum - (PW+1)'(DEPTH);
    return sum[PW-1:0];
  endfunction

  logic [1:0] pushCnt;
  logic [PW-1:0] tailNext1;
  assign pushCnt   = {1'b0, push0} + {1'b0, push1};
  assign tailNext1 = advance(tailPtr, {1'b0, push0});
  assign headTag0  = slotMem[headPtr];
  assign headTag1  = slotMem[advance(headPtr, 2'd1)];
  assign freeCount = countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) slotMem[i] <= TW'(NUM_ARCH + i);
      headPtr <= '0;
      tailPtr <= '0;
      countQ  <= CW'(DEPTH);
    end else begin
      if (push0) slotMem[tailPtr] <= pushTag0;
      if (push1) slotMem[tailNext1] <= pushTag1;
      headPtr <= advance(headPtr, popCnt);
      tailPtr <= advance(tailPtr, pushCnt);
      countQ  <= countQ - CW'(popCnt) + CW'(pushCnt);
    end
  end

  // R7: never hand out more tags than are queued
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    CW'(popCnt) <= countQ);
  // R8: returned tags never exceed the queue capacity
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (CW+1)'(countQ) + (CW+1)'(pushCnt) <= (CW+1)'(DEPTH) + (CW+1)'(popCnt));
endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid0,
  input  logic          dstEn0,
  input  logic          valid1,
  input  logic          dstEn1,
  input  logic          relValid0,
  input  logic          relValid1,
  input  logic [CW-1:0] freeCount,
  output logic          ready,
  output rnStrobe_t     strobe
);
  logic want0, want1;
  logic [1:0] needCnt;
  logic fire;

  assign want0   = valid0 & dstEn0;
  assign want1   = valid1 & dstEn1;
  assign needCnt = {1'b0, want0} + {1'b0, want1};
  assign ready   = freeCount >= CW'(needCnt);
  assign fire    = ready & (valid0 | valid1);

  always_comb begin
    strobe.req0   = want0;
    strobe.alloc0 = fire & want0;
    strobe.alloc1 = fire & want1;
    strobe.push0  = relValid0;
    strobe.push1  = relValid1;
  end

  // R7: a refused group takes no tag
  a_r7_refuse_no_alloc: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !(strobe.alloc0 || strobe.alloc1));
endmodule

// File: rtl/rn_datapath.sv
module rn_datapath
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 192,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  rnStrobe_t     strobe,
  input  logic [AW-1:0] srcA0,
  input  logic [AW-1:0] srcB0,
  input  logic [AW-1:0] dst0,
  input  logic [AW-1:0] srcA1,
  input  logic [AW-1:0] srcB1,
  input  logic [AW-1:0] dst1,
  input  logic [TW-1:0] relTag0,
  input  logic [TW-1:0] relTag1,
  output logic [CW-1:0] freeCount,
  output logic [TW-1:0] physA0,
  output logic [TW-1:0] physB0,
  output logic [TW-1:0] physDst0,
  output logic [TW-1:0] physOld0,
  output logic [TW-1:0] physA1,
  output logic [TW-1:0] physB1,
  output logic [TW-1:0] physDst1,
  output logic [TW-1:0] physOld1
);
  logic [TW-1:0] mapTab [NUM_ARCH];
  logic [TW-1:0] headTag0, headTag1;
  logic [1:0] popCnt;

  assign popCnt = {1'b0, strobe.alloc0} + {1'b0, strobe.alloc1};

  rn_freelist #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) uFree (
    .clk(clk), .rstN(rstN), .popCnt(popCnt),
    .push0(strobe.push0), .pushTag0(relTag0),
    .push1(strobe.push1), .pushTag1(relTag1),
    .headTag0(headTag0), .headTag1(headTag1), .freeCount(freeCount)
  );

  // slot 1 takes the second queued tag only if slot 0 took the first
  assign physDst0 = headTag0;
  assign physDst1 = strobe.req0 ? headTag1 : headTag0;

  // slot 0 reads the table directly
  assign physA0   = mapTab[srcA0];
  assign physB0   = mapTab[srcB0];
  assign physOld0 = mapTab[dst0];

  // slot 1 sees slot 0's new tag on a match
  logic hitA1, hitB1, hitD1;
  assign hitA1 = strobe.req0 && (srcA1 == dst0);
  assign hitB1 = strobe.req0 && (srcB1 == dst0);
  assign hitD1 = strobe.req0 && (dst1 == dst0);
  assign physA1   = hitA1 ? physDst0 : mapTab[srcA1];
  assign physB1   = hitB1 ? physDst0 : mapTab[srcB1];
  assign physOld1 = hitD1 ? physDst0 : mapTab[dst1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ARCH; i++) mapTab[i] <= TW'(i);
    end else begin
      if (strobe.alloc0) mapTab[dst0] <= physDst0;
      if (strobe.alloc1) mapTab[dst1] <= physDst1;  // later slot wins
    end
  end

  // R3: two tags handed out together are distinct
  a_r3_distinct_tags: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc0 && strobe.alloc1) |-> (physDst0 != physDst1));
  // R4: the new tag differs from the mapping it replaces
  a_r4_fresh_tag: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc0 |-> (physOld0 != physDst0));
  // R6: same destination in both slots leaves slot 1's tag in the table
  a_r6_last_writer: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.alloc0 && strobe.alloc1 && dst0 == dst1) |=> (mapTab[$past(dst1)] == $past(physDst1)));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 192,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          valid0,
  input  logic          dstEn0,
  input  logic [AW-1:0] srcA0,
  input  logic [AW-1:0] srcB0,
  input  logic [AW-1:0] dst0,
  input  logic          valid1,
  input  logic          dstEn1,
  input  logic [AW-1:0] srcA1,
  input  logic [AW-1:0] srcB1,
  input  logic [AW-1:0] dst1,
  output logic          ready,
  output logic [TW-1:0] physA0,
  output logic [TW-1:0] physB0,
  output logic [TW-1:0] physDst0,
  output logic [TW-1:0] physOld0,
  output logic [TW-1:0] physA1,
  output logic [TW-1:0] physB1,
  output logic [TW-1:0] physDst1,
  output logic [TW-1:0] physOld1,
  input  logic          relValid0,
  input  logic [TW-1:0] relTag0,
  input  logic          relValid1,
  input  logic [TW-1:0] relTag1
);
  rnStrobe_t strobe;
  logic [CW-1:0] freeCount;

  rn_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .valid0(valid0), .dstEn0(dstEn0), .valid1(valid1), .dstEn1(dstEn1),
    .relValid0(relValid0), .relValid1(relValid1),
    .freeCount(freeCount), .ready(ready), .strobe(strobe)
  );

  rn_datapath #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA0(srcA0), .srcB0(srcB0), .dst0(dst0),
    .srcA1(srcA1), .srcB1(srcB1), .dst1(dst1),
    .relTag0(relTag0), .relTag1(relTag1), .freeCount(freeCount),
    .physA0(physA0), .physB0(physB0), .physDst0(physDst0), .physOld0(physOld0),
    .physA1(physA1), .physB1(physB1), .physDst1(physDst1), .physOld1(physOld1)
  );
endmodule

// File: tb/rename_unit_test.sv
module rename_unit_test;
  logic clk = 0, rstN = 0;
  logic valid0 = 0, dstEn0 = 0, valid1 = 0, dstEn1 = 0;
  logic [3:0] srcA0 = 0, srcB0 = 0, dst0 = 0, srcA1 = 0, srcB1 = 0, dst1 = 0;
  logic ready;
  logic [7:0] physA0, physB0, physDst0, physOld0, physA1, physB1, physDst1, physOld1;
  logic relValid0 = 0, relValid1 = 0;
  logic [7:0] relTag0 = 0, relTag1 = 0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rename_unit uut (.*);

  typedef struct packed {
    logic v0, e0; logic [3:0] a0, b0, d0;
    logic v1, e1; logic [3:0] a1, b1, d1;
    logic [7:0] xa0, xb0, xd0, xo0, xa1, xb1, xd1, xo1;
  } vec_t;

  // hand-computed from R1..R6 starting at reset state
  localparam vec_t VECS[5] = '{
    '{1,1,4'd1,4'd2,4'd3,   1,1,4'd3,4'd4,4'd5,   8'd1,8'd2,8'd16,8'd3,   8'd16,8'd4,8'd17,8'd5},
    '{1,1,4'd3,4'd5,4'd3,   1,1,4'd3,4'd0,4'd3,   8'd16,8'd17,8'd18,8'd16, 8'd18,8'd0,8'd19,8'd18},
    '{1,0,4'd3,4'd5,4'd7,   1,1,4'd7,4'd3,4'd7,   8'd19,8'd17,8'd0,8'd0,  8'd7,8'd19,8'd20,8'd7},
    '{0,0,4'd0,4'd0,4'd0,   1,1,4'd7,4'd15,4'd15, 8'd0,8'd0,8'd0,8'd0,    8'd20,8'd15,8'd21,8'd15},
    '{1,1,4'd15,4'd15,4'd0, 1,1,4'd0,4'd1,4'd2,   8'd21,8'd21,8'd22,8'd0, 8'd22,8'd1,8'd23,8'd2}
  };

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setIn(input logic v0, e0, input logic [3:0] a0, b0, d0,
                       input logic v1, e1, input logic [3:0] a1, b1, d1);
    valid0 = v0; dstEn0 = e0; srcA0 = a0; srcB0 = b0; dst0 = d0;
    valid1 = v1; dstEn1 = e1; srcA1 = a1; srcB1 = b1; dst1 = d1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;

    // R1 reset mapping and ready
    setIn(1, 1, 4'd9, 4'd14, 4'd6, 1, 1, 4'd11, 4'd12, 4'd8);
    valid0 = 0; valid1 = 0;
    #1;
    check(ready, 1, "R1 ready after reset");
    check(physA0, 9, "R1 map of r9");
    check(physB0, 14, "R1 map of r14");
    check(physA1, 11, "R1 map of r11");

    // table walk: R2 lookup, R3 alloc, R4 old tag, R5 bypass, R6 same dest
    foreach (VECS[i]) begin
      @(negedge clk);
      setIn(VECS[i].v0, VECS[i].e0, VECS[i].a0, VECS[i].b0, VECS[i].d0,
            VECS[i].v1, VECS[i].e1, VECS[i].a1, VECS[i].b1, VECS[i].d1);
      #1;
      check(ready, 1, "R3 ready with tags left");
      if (VECS[i].v0) begin
        check(physA0, VECS[i].xa0, "R2 slot0 srcA");
        check(physB0, VECS[i].xb0, "R2 slot0 srcB");
        if (VECS[i].e0) begin
          check(physDst0, VECS[i].xd0, "R3 slot0 new tag");
          check(physOld0, VECS[i].xo0, "R4 slot0 old tag");
        end
      end
      if (VECS[i].v1) begin
        check(physA1, VECS[i].xa1, "R5 slot1 srcA");
        check(physB1, VECS[i].xb1, "R5 slot1 srcB");
        if (VECS[i].e1) begin
          check(physDst1, VECS[i].xd1, "R3 slot1 new tag");
          check(physOld1, VECS[i].xo1, "R6 slot1 old tag");
        end
      end
    end

    // R6: table holds slot 1's tag for r3 (19)
    @(negedge clk);
    setIn(1, 0, 4'd3, 4'd5, 4'd0, 0, 0, 4'd0, 4'd0, 4'd0);
    #1;
    check(physA0, 19, "R6 table keeps slot1 tag");
    check(physB0, 17, "R2 r5 mapping");

    // drain the queue down to one tag (next tag 24 .. 190)
    for (int g = 0; g < 83; g++) begin
      @(negedge clk);
      setIn(1, 1, 4'd0, 4'd0, 4'd10, 1, 1, 4'd0, 4'd0, 4'd11);
    end
    @(negedge clk);
    setIn(1, 1, 4'd0, 4'd0, 4'd10, 0, 0, 4'd0, 4'd0, 4'd0);
    #1;
    check(physDst0, 190, "R3 in-order tags while draining");

    // R7: two needed, one left
    @(negedge clk);
    setIn(1, 1, 4'd0, 4'd0, 4'd9, 1, 1, 4'd0, 4'd0, 4'd8);
    #1;
    check(ready, 0, "R7 ready low when short");
    @(negedge clk);
    setIn(1, 1, 4'd9, 4'd8, 4'd12, 0, 0, 4'd0, 4'd0, 4'd0);
    #1;
    check(ready, 1, "R7 single still fits");
    check(physA0, 9, "R7 refused group left r9");
    check(physB0, 8, "R7 refused group left r8");
    check(physDst0, 191, "R7 refused group took no tag");

    // queue now empty: a group without destinations is accepted
    @(negedge clk);
    setIn(1, 0, 4'd12, 4'd1, 4'd0, 1, 0, 4'd2, 4'd3, 4'd0);
    #1;
    check(ready, 1, "R7 no-dest group accepted when empty");
    check(physA0, 191, "R2 r12 mapped to last tag");

    // R8: retire 3 and 5; not usable in the same cycle
    @(negedge clk);
    setIn(1, 1, 4'd0, 4'd0, 4'd13, 0, 0, 4'd0, 4'd0, 4'd0);
    relValid0 = 1; relTag0 = 8'd3; relValid1 = 1; relTag1 = 8'd5;
    #1;
    check(ready, 0, "R8 retired tag not usable same cycle");
    @(negedge clk);
    relValid0 = 0; relValid1 = 0;
    setIn(1, 1, 4'd0, 4'd0, 4'd13, 1, 1, 4'd0, 4'd0, 4'd14);
    #1;
    check(ready, 1, "R8 retired tags usable next cycle");
    check(physDst0, 3, "R8 retire slot0 queued first");
    check(physDst1, 5, "R8 retire slot1 queued second");

    // R9: retire 16 then 18 in separate cycles, using each port slot
    @(negedge clk);
    setIn(0, 0, 4'd0, 4'd0, 4'd0, 0, 0, 4'd0, 4'd0, 4'd0);
    relValid1 = 1; relTag1 = 8'd16;
    @(negedge clk);
    relValid1 = 0; relValid0 = 1; relTag0 = 8'd18;
    @(negedge clk);
    relValid0 = 0;
    setIn(1, 1, 4'd13, 4'd0, 4'd4, 1, 1, 4'd4, 4'd14, 4'd6);
    #1;
    check(ready, 1, "R9 two tags back");
    check(physDst0, 16, "R9 first retired first out");
    check(physDst1, 18, "R9 second retired second out");
    check(physA0, 3, "R2 r13 mapping");
    check(physA1, 16, "R5 bypass after wrap");
    check(physB1, 5, "R2 r14 mapping");
    @(negedge clk);
    setIn(0, 0, 4'd0, 4'd0, 4'd0, 0, 0, 4'd0, 4'd0, 4'd0);
    #1;
    check(ready, 1, "R7 idle group accepted");

    summary();
  end
endmodule